// File: doc/BRIEF.md
# Banked Register File with Status

This block holds the working registers of a 32-bit processor core: two complete banks of sixteen general registers, a primary one and an alternate one. Beside them sit a small set of control registers, the first of which is the status word. One bit of the status word decides which bank the general-register ports reach. Software can therefore swap its whole working set, for example on entry to an interrupt handler, with a single status write.

The general side has two combinational read ports and one clocked write port. A separate port reads and writes the control registers. A dedicated carry input updates the carry flag without disturbing the rest of the status word. The block also holds the program counter at its reset value for the fetch logic. Instruction fetch, exception entry and trap handling live elsewhere.

After reset the primary bank is active. Register 0 of the primary bank holds a stack pointer derived from the memory size, and register 5 holds a copy of it.

Top module: `banked_regfile`

## Requirements
- R1: There are two banks of 16 registers of 32 bits. Status bit 1 selects the bank: 0 selects the primary bank and 1 selects the alternate bank. All general-register ports use the selected bank.
- R2: Reset is synchronous and active low. It leaves the status word at 0 and the program counter at PC_RESET (0 by default). Every register of both banks reads 0, with two exceptions in the primary bank: register 0 and register 5 both hold (MEM_BYTES - 4) rounded down to a multiple of 8. With the default MEM_BYTES of 0x0080_0000, that value is 0x007F_FFF8.
- R3: The two read ports are combinational and independent. Any pair of addresses, including two equal addresses, returns the stored values of the active bank.
- R4: When wr_en is high, a write stores wr_data in register wr_addr of the active bank at the clock edge. The other bank and the other registers keep their contents.
- R5: When wr_en is high and a read address equals wr_addr, that read port returns wr_data in the same cycle.
- R6: A status write that changes bit 1 affects register accesses from the following cycle on. Accesses in the cycle of the write still use the old bank.
- R7: The control port uses a 5-bit address. Slots 0 to 12 are read/write registers, and slot 0 is the status word. Slots 13 to 31 read as 0, and writes to them are ignored.
- R8: A carry update (carry_we) sets status bit 0 to carry_in and leaves bits 31..1 unchanged. If a status write happens in the same cycle, bits 31..1 come from the write and bit 0 comes from carry_in.
- R9: carry_out shows status bit 0 and bank_sel shows status bit 1. status_out shows the whole status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_addr | input | 4 | Read port A register address |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register address |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 4 | General register write address |
| wr_data | input | 32 | General register write data |
| cr_addr | input | 5 | Control register slot address |
| cr_wr_en | input | 1 | Control register write enable |
| cr_wr_data | input | 32 | Control register write data |
| cr_rd_data | output | 32 | Control register read data |
| carry_we | input | 1 | Carry flag update enable |
| carry_in | input | 1 | New carry value |
| carry_out | output | 1 | Current carry flag |
| bank_sel | output | 1 | Current bank select |
| status_out | output | 32 | Full status word |
| pc_out | output | 32 | Program counter value |

## Verification
The bench first reads both banks right after reset. This separates the stack-pointer and copy registers from the cleared ones, and the primary bank from the alternate one. It then fills each bank with its own pattern, derived from the bank and the index, and reads every ordered address pair. A fault in port decoding, or a leak between banks, therefore shows up as a wrong value. Writes paired with same-address and neighbouring-address reads separate the bypass path from the stored path. A status write paired with a read in the same cycle separates immediate bank switching from switching in the next cycle. Finally, the bench sweeps all 32 control slots and drives carry updates with and without a simultaneous status write. This shows which bits each source owns.

// File: rtl/regfile_pkg.sv
// Package: shared widths and reset-value computation for the banked
// register file. Assumes 32-bit words and a byte-sized memory that is
// at least 8 bytes.
package regfile_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SP_INDEX = 0;
    localparam int unsigned SP_COPY  = 5;
    localparam int unsigned CARRY_BIT = 0;
    localparam int unsigned BANK_BIT  = 1;

    typedef logic [WORD_W-1:0] word_t;

    // Initial stack pointer: memory size minus one word, 8-byte aligned.
    function automatic word_t stack_top(input word_t mem_bytes);
        word_t raw;
        raw = mem_bytes - word_t'(4);
        return raw & ~word_t'(7);
    endfunction

    // Reset value of general register idx in the given bank.
    function automatic word_t gpr_reset_value(input int idx, input bit primary,
                                              input word_t mem_bytes);
        if (primary && (idx == SP_INDEX || idx == SP_COPY))
            return stack_top(mem_bytes);
        return '0;
    endfunction
endpackage

// File: rtl/rf_bank.sv
// Module: one bank of general registers with two combinational read
// ports and one write port. Assumes the caller gates we with bank
// selection; reset values come from the package function.
module rf_bank
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 16,
    parameter bit          IS_PRIMARY = 1'b1,
    parameter word_t       MEM_BYTES = 32'h0080_0000,
    localparam int unsigned AW = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output word_t         rdata_a,
    output word_t         rdata_b
);
    word_t regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam word_t RST_VAL = gpr_reset_value(i, IS_PRIMARY, MEM_BYTES);

        // Hold register i; load on reset or on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= RST_VAL;
            else if (we && waddr == AW'(i))
                regs[i] <= wdata;
        end

        // R4: a register not addressed by a write keeps its value
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!we || waddr != AW'(i)) |=> regs[i] == $past(regs[i]));

        // R2: the cycle after reset shows the defined initial value
        a_r2_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!rst_n) |-> regs[i] == RST_VAL);
    end

    // Read both ports straight from the array.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end
endmodule

// File: rtl/rf_ctrl.sv
// Module: control register slots, status word with carry update, and
// the program counter holder. Assumes slot 0 is the status word and
// slots at or above NUM_IMPL are absent.
module rf_ctrl
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned NUM_IMPL  = 13,
    parameter word_t       PC_RESET  = '0,
    localparam int unsigned CAW = $clog2(NUM_SLOTS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CAW-1:0] cr_addr,
    input  logic           cr_wr_en,
    input  word_t          cr_wr_data,
    output word_t          cr_rd_data,
    input  logic           carry_we,
    input  logic           carry_in,
    output word_t          status,
    output word_t          pc
);
    word_t cregs [NUM_IMPL];
    logic  sr_write;

    assign sr_write = cr_wr_en && cr_addr == '0;

    // Status word: a write sets the upper bits; a carry update owns bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cregs[0] <= '0;
        else begin
            if (sr_write)
                cregs[0] <= cr_wr_data;
            if (carry_we)
                cregs[0][CARRY_BIT] <= carry_in;
        end
    end

    for (genvar i = 1; i < NUM_IMPL; i++) begin : g_creg
        // Plain control slot i: cleared on reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cregs[i] <= '0;
            else if (cr_wr_en && cr_addr == CAW'(i))
                cregs[i] <= cr_wr_data;
        end
    end

    // Program counter holder: no fetch here, so it keeps its reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= PC_RESET;
    end

    // Read mux: absent slots return zero.
    always_comb begin
        cr_rd_data = '0;
        for (int i = 0; i < NUM_IMPL; i++)
            if (cr_addr == CAW'(i))
                cr_rd_data = cregs[i];
    end

    assign status = cregs[0];

    // R7: absent slots read as zero
    a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cr_addr) >= NUM_IMPL) |-> cr_rd_data == '0);

    // R8: carry update writes bit 0 from carry_in
    a_r8_carry_value: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |=> status[CARRY_BIT] == $past(carry_in));

    // R8: carry update alone keeps the other status bits
    a_r8_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we && !sr_write) |=> status[WORD_W-1:1] == $past(status[WORD_W-1:1]));
endmodule

// File: rtl/banked_regfile.sv
// Module: top of the banked register file. Routes the general ports to
// the bank chosen by status bit 1, bypasses same-cycle writes to reads,
// and exposes the control port. Assumes one write per cycle per side.
module banked_regfile
    import regfile_pkg::*;
#(
    parameter int unsigned NUM_REGS  = 16,
    parameter int unsigned NUM_SLOTS = 32,
    parameter int unsigned NUM_IMPL  = 13,
    parameter word_t       MEM_BYTES = 32'h0080_0000,
    parameter word_t       PC_RESET  = '0,
    localparam int unsigned AW  = $clog2(NUM_REGS),
    localparam int unsigned CAW = $clog2(NUM_SLOTS),
    localparam int unsigned NUM_BANKS = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  rd_a_addr,
    output logic [31:0]    rd_a_data,
    input  logic [AW-1:0]  rd_b_addr,
    output logic [31:0]    rd_b_data,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [31:0]    wr_data,
    input  logic [CAW-1:0] cr_addr,
    input  logic           cr_wr_en,
    input  logic [31:0]    cr_wr_data,
    output logic [31:0]    cr_rd_data,
    input  logic           carry_we,
    input  logic           carry_in,
    output logic           carry_out,
    output logic           bank_sel,
    output logic [31:0]    status_out,
    output logic [31:0]    pc_out
);
    word_t status;
    word_t bank_a [NUM_BANKS];
    word_t bank_b [NUM_BANKS];
    logic  active;

    rf_ctrl #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_IMPL  (NUM_IMPL),
        .PC_RESET  (PC_RESET)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cr_addr    (cr_addr),
        .cr_wr_en   (cr_wr_en),
        .cr_wr_data (cr_wr_data),
        .cr_rd_data (cr_rd_data),
        .carry_we   (carry_we),
        .carry_in   (carry_in),
        .status     (status),
        .pc         (pc_out)
    );

    assign active = status[BANK_BIT];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rf_bank #(
            .NUM_REGS   (NUM_REGS),
            .IS_PRIMARY (b == 0),
            .MEM_BYTES  (MEM_BYTES)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we      (wr_en && (active == 1'(b))),
            .waddr   (wr_addr),
            .wdata   (wr_data),
            .raddr_a (rd_a_addr),
            .raddr_b (rd_b_addr),
            .rdata_a (bank_a[b]),
            .rdata_b (bank_b[b])
        );
    end

    // Pick the active bank and forward a same-cycle write to each port.
    always_comb begin
        rd_a_data = bank_a[active];
        rd_b_data = bank_b[active];
        if (wr_en && wr_addr == rd_a_addr)
            rd_a_data = wr_data;
        if (wr_en && wr_addr == rd_b_addr)
            rd_b_data = wr_data;
    end

    assign carry_out  = status[CARRY_BIT];
    assign bank_sel   = active;
    assign status_out = status;

    // R6: the bank changes only after a status write
    a_r6_bank_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cr_wr_en && cr_addr == '0)) |-> $stable(bank_sel));

    // R4/R5: a value written is read back next cycle on port A, same bank
    a_r5_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && rd_a_addr == $past(wr_addr)
         && bank_sel == $past(bank_sel) && !wr_en) |-> rd_a_data == $past(wr_data));
endmodule

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en;
    logic [4:0]  cr_addr;
    logic        cr_wr_en;
    logic [31:0] cr_wr_data, cr_rd_data;
    logic        carry_we, carry_in, carry_out, bank_sel;
    logic [31:0] status_out, pc_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] exp_bank [2][16];
    logic [31:0] exp_cr [32];

    localparam logic [31:0] SP = 32'h007F_FFF8;

    always #2 clk = ~clk;

    banked_regfile u0 (.*);

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int b, input int i);
        return 32'hA500_0000 ^ (32'(b) << 20) ^ (32'(i) * 32'h0101_0101);
    endfunction

    task automatic idle();
        wr_en = 0; cr_wr_en = 0; carry_we = 0;
    endtask

    // Write status word at the next edge and check the bank timing (R6).
    task automatic set_bank(input int b);
        @(negedge clk);
        idle();
        cr_addr = 0; cr_wr_en = 1; cr_wr_data = 32'(b) << 1;
        rd_a_addr = 0;
        #1 check(rd_a_data, exp_bank[bank_sel][0], "R6 old bank same cycle");
        @(negedge clk);
        idle();
        exp_cr[0] = 32'(b) << 1;
        #1 check({31'b0, bank_sel}, 32'(b), "R9 bank_sel");
    endtask

    task automatic fill(input int b);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            idle();
            wr_en = 1; wr_addr = 4'(i); wr_data = pat(b, i);
            rd_a_addr = 4'(i); rd_b_addr = 4'((i + 1) % 16);
            #1;
            check(rd_a_data, pat(b, i), "R5 bypass");
            check(rd_b_data, exp_bank[b][(i + 1) % 16], "R5 no bypass other addr");
            exp_bank[b][i] = pat(b, i);
        end
        @(negedge clk);
        idle();
    endtask

    task automatic sweep(input int b, input bit all_pairs);
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                if (!all_pairs && j != 15 - i) continue;
                @(negedge clk);
                idle();
                rd_a_addr = 4'(i); rd_b_addr = 4'(j);
                #1;
                check(rd_a_data, exp_bank[b][i], "R3 port A");
                check(rd_b_data, exp_bank[b][j], "R3 port B");
            end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle(); rd_a_addr = 0; rd_b_addr = 0; wr_addr = 0; wr_data = 0;
        cr_addr = 0; cr_wr_data = 0; carry_in = 0;
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++)
                exp_bank[b][i] = (b == 0 && (i == 0 || i == 5)) ? SP : 32'h0;
        for (int i = 0; i < 32; i++) exp_cr[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R2: reset state
        #1;
        check(status_out, 0, "R2 status");
        check(pc_out, 0, "R2 pc");
        check({31'b0, carry_out}, 0, "R9 carry_out");
        sweep(0, 0);
        set_bank(1);
        sweep(1, 0);              // R1: alternate bank cleared

        fill(1);                  // R4 alternate bank
        set_bank(0);
        sweep(0, 0);              // R4: primary untouched by alternate writes
        fill(0);
        sweep(0, 1);              // R3: all pairs
        set_bank(1);
        sweep(1, 1);              // R1: banks distinct
        set_bank(0);

        // R7: control slots
        for (int i = 1; i < 32; i++) begin
            @(negedge clk);
            idle();
            cr_addr = 5'(i); cr_wr_en = 1; cr_wr_data = 32'hC0DE_0000 | 32'(i);
            if (i < 13) exp_cr[i] = 32'hC0DE_0000 | 32'(i);
        end
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            idle();
            cr_addr = 5'(i);
            #1 check(cr_rd_data, exp_cr[i], "R7 control slot");
        end

        // R8: carry set alone
        @(negedge clk);
        idle(); carry_we = 1; carry_in = 1;
        @(negedge clk);
        idle(); #1;
        check(status_out, 32'h0000_0001, "R8 carry set");
        check({31'b0, carry_out}, 1, "R9 carry_out");
        check({31'b0, bank_sel}, 0, "R8 bank bit kept");
        // R8: status write with carry clear in same cycle
        @(negedge clk);
        idle(); cr_addr = 0; cr_wr_en = 1; cr_wr_data = 32'h1234_5671; carry_we = 1; carry_in = 0;
        @(negedge clk);
        idle(); #1;
        check(status_out, 32'h1234_5670, "R8 write plus carry");
        // R8: carry set keeps upper bits
        @(negedge clk);
        idle(); carry_we = 1; carry_in = 1;
        @(negedge clk);
        idle(); #1;
        check(status_out, 32'h1234_5671, "R8 upper bits kept");
        check(pc_out, 0, "R2 pc holds");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule